// File: doc/BRIEF.md
# Burst Column Sequencer for Synchronous DRAM

This block produces the column address for every data beat of a synchronous DRAM burst. When a read or write command is accepted, the block captures the start column, a two-bit burst-length code and the ordering select. On each clock where the clock-enable qualifier is high it then steps through the burst, and it marks the final beat. The low bits of the column wrap inside an aligned block whose size is the burst length. The bits above that block never change during a burst.

Two orderings are available, and both use the same captured start column. The linear ordering counts upward inside the block and wraps around. The interleaved ordering XORs the beat number into the low bits. Holding the clock-enable low freezes the sequence where it is, so the block follows clock suspend. A new command can restart the burst at any beat, and a terminate request cuts the burst short.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted and directly after it, `valid` and `last` are 0 and `col` is 0.
- R2: A clock edge with `start` and `clkEn` both high captures `startCol`. On the next cycle `valid` is 1 and `col` equals the captured start column.
- R3: `blCode` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. With no interruption, `valid` stays high for exactly that many enabled clocks.
- R4: With `burstType` = 0 (linear), beat k carries low bits equal to (start low bits + k) modulo the burst length.
- R5: With `burstType` = 1 (interleaved), beat k carries low bits equal to the start low bits XOR k.
- R6: The column bits above the low log2(burst length) bits keep their start values on every beat of a burst.
- R7: `last` is high only on the final beat. With a burst length of 1, `last` is high on the first and only beat.
- R8: On a clock edge where `clkEn` is low, `col`, `valid` and `last` hold their values, and a `start` on that edge is ignored.
- R9: An accepted `start` while a burst is running restarts the sequence at beat 0 from the new column, length and ordering.
- R10: `terminate` drops `valid` on the next clock whatever the state of `clkEn`. An accepted `start` on the same edge takes priority over it.
- R11: While `valid` is low, `col` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command accepted: begin a burst (qualified by clkEn) |
| startCol | input | COL_W | First column of the burst |
| blCode | input | 2 | Burst length code (0:1, 1:2, 2:4, 3:8) |
| burstType | input | 1 | 0 linear ordering, 1 interleaved ordering |
| clkEn | input | 1 | Clock qualifier; low freezes the sequence |
| terminate | input | 1 | End the running burst early |
| col | output | COL_W | Column address of the current beat |
| valid | output | 1 | A beat is being presented |
| last | output | 1 | Current beat is the final one |

## Verification
The bench builds the block with the default column width of 9. It uses start columns that set the upper bits high, including all ones, so any carry from the wrap block into the upper bits would show up. The start values for the low bits are chosen so that every burst length wraps part way through in linear order, and the interleaved order visits the values out of sequence. Clock-enable gaps, restarts and terminations are placed on middle beats, on final beats and on the same edge as a start, so that the priority between these inputs is exercised.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int BEAT_W = 3;

  typedef enum logic {
    BURST_LIN = 1'b0,
    BURST_ILV = 1'b1
  } burst_e;

  typedef struct packed {
    logic              load;
    logic              active;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] mask;
  } colgen_ctrl_t;

  function automatic logic [BEAT_W-1:0] lenMask(input logic [1:0] code);
    logic [BEAT_W:0] one;
    one = 1;
    return BEAT_W'((one << code) - 1);
  endfunction
endpackage

// File: rtl/colgen_ctrl.sv
module colgen_ctrl
  import colgen_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   blCode,
  input  logic         clkEn,
  input  logic         terminate,
  output colgen_ctrl_t ctrl,
  output logic         valid,
  output logic         last
);
  logic              validQ;
  logic [BEAT_W-1:0] beatQ;
  logic [BEAT_W-1:0] maskQ;
  logic              accept;
  logic              atEnd;

  assign accept = start && clkEn;
  assign atEnd  = (beatQ == maskQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      beatQ  <= '0;
      maskQ  <= '0;
    end else if (accept) begin
      validQ <= 1'b1;
      beatQ  <= '0;
      maskQ  <= lenMask(blCode);
    end else if (terminate) begin
      validQ <= 1'b0;
    end else if (clkEn && validQ) begin
      if (atEnd) validQ <= 1'b0;
      else       beatQ  <= beatQ + 1'b1;
    end
  end

  always_comb begin
    ctrl.load   = accept;
    ctrl.active = validQ;
    ctrl.beat   = beatQ;
    ctrl.mask   = maskQ;
  end

  assign valid = validQ;
  assign last  = validQ && atEnd;
endmodule

// File: rtl/colgen_datapath.sv
module colgen_datapath
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [COL_W-1:0] startCol,
  input  logic             burstType,
  input  colgen_ctrl_t     ctrl,
  output logic [COL_W-1:0] col
);
  localparam int UP_W = COL_W - BEAT_W;

  logic [COL_W-1:0]  baseQ;
  burst_e            modeQ;
  logic [BEAT_W-1:0] lowBase;
  logic [BEAT_W-1:0] linLow;
  logic [BEAT_W-1:0] ilvLow;
  logic [BEAT_W-1:0] pick;
  logic [BEAT_W-1:0] mixed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      modeQ <= BURST_LIN;
    end else if (ctrl.load) begin
      baseQ <= startCol;
      modeQ <= burst_e'(burstType);
    end
  end

  always_comb begin
    lowBase = baseQ[BEAT_W-1:0];
    linLow  = lowBase + ctrl.beat;
    ilvLow  = lowBase ^ ctrl.beat;
    pick    = (modeQ == BURST_ILV) ? ilvLow : linLow;
    mixed   = (lowBase & ~ctrl.mask) | (pick & ctrl.mask);
  end

  generate
    if (UP_W > 0) begin : g_upper
      assign col = ctrl.active ? {baseQ[COL_W-1:BEAT_W], mixed} : '0;
    end else begin : g_flat
      assign col = ctrl.active ? mixed[COL_W-1:0] : '0;
    end
  endgenerate
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [COL_W-1:0] startCol,
  input  logic [1:0]       blCode,
  input  logic             burstType,
  input  logic             clkEn,
  input  logic             terminate,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic             last
);
  colgen_ctrl_t ctrl;

  colgen_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .blCode(blCode),
    .clkEn(clkEn), .terminate(terminate), .ctrl(ctrl),
    .valid(valid), .last(last)
  );

  colgen_datapath #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .startCol(startCol), .burstType(burstType),
    .ctrl(ctrl), .col(col)
  );
endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [COL_W-1:0] startCol,
  input logic             clkEn,
  input logic             terminate,
  input logic [COL_W-1:0] col,
  input logic             valid,
  input logic             last
);
  logic acc;
  assign acc = start && clkEn;

  p_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    acc |=> (valid && col == $past(startCol)));

  p_continue_r3: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !last && clkEn && !start && !terminate) |=> valid);

  p_upper_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !last && clkEn && !start && !terminate) |=> $stable(col[COL_W-1:3]));

  p_end_after_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    (last && clkEn && !start && !terminate) |=> !valid);

  p_freeze_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && !terminate) |=> ($stable(col) && $stable(valid) && $stable(last)));

  p_terminate_r10: assert property (@(posedge clk) disable iff (!rstN)
    (terminate && !acc) |=> !valid);

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    !valid |-> (col == '0 && !last));
endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .startCol(startCol),
  .clkEn(clkEn), .terminate(terminate), .col(col), .valid(valid), .last(last)
);

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;
  localparam int COL_W = 9;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [1:0]       blCode = '0;
  logic             burstType = 1'b0;
  logic             clkEn = 1'b1;
  logic             terminate = 1'b0;
  logic [COL_W-1:0] col;
  logic             valid;
  logic             last;

  int nChecks = 0;
  int nFails  = 0;

  int mValid = 0, mBeat = 0, mLen = 1, mBase = 0, mType = 0;

  always #10 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .startCol(startCol),
    .blCode(blCode), .burstType(burstType), .clkEn(clkEn),
    .terminate(terminate), .col(col), .valid(valid), .last(last)
  );

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  task automatic compare(input string tag);
    int expCol, expValid, expLast, blockBase, off;
    if (mValid != 0) begin
      blockBase = mBase - (mBase % mLen);
      if (mType == 0) off = ((mBase % mLen) + mBeat) % mLen;
      else            off = (mBase % mLen) ^ mBeat;
      expCol   = blockBase + off;
      expValid = 1;
      expLast  = (mBeat == mLen - 1) ? 1 : 0;
    end else begin
      expCol = 0; expValid = 0; expLast = 0;
    end
    nChecks++;
    if (int'(col) != expCol || int'(valid) != expValid || int'(last) != expLast) begin
      nFails++;
      $display("FAIL %s: actual col=%0h valid=%0d last=%0d expected col=%0h valid=%0d last=%0d",
               tag, col, valid, last, expCol, expValid, expLast);
    end
  endtask

  task automatic step(input bit st, input int sc, input int code, input bit bt,
                      input bit ce, input bit term, input string tag);
    @(negedge clk);
    start = st; startCol = COL_W'(sc); blCode = 2'(code);
    burstType = bt; clkEn = ce; terminate = term;
    @(posedge clk);
    if (ce && st) begin
      mValid = 1; mBeat = 0; mLen = 1 << code; mBase = sc; mType = bt;
    end else if (term) begin
      mValid = 0;
    end else if (ce && mValid != 0) begin
      if (mBeat == mLen - 1) mValid = 0;
      else mBeat++;
    end
    #5;
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, 0, tag);
  endtask

  initial begin
    #25;
    compare("R1 during reset");
    @(negedge clk);
    rstN = 1'b1;
    #15;
    compare("R1 after reset");

    // R4 R6 linear, length 8, wrap part way
    step(1, 'h1F5, 3, 0, 1, 0, "R2 R4 start lin8");
    idle(9, "R3 R4 R6 R7 R11 lin8 beats");
    // R5 interleaved length 8
    step(1, 'h0A3, 3, 1, 1, 0, "R2 R5 start ilv8");
    idle(9, "R3 R5 R6 R7 ilv8 beats");
    // lengths 4, 2, 1
    step(1, 'h006, 2, 0, 1, 0, "R3 R4 lin4");
    idle(5, "R3 R4 R7 lin4 beats");
    step(1, 'h1FF, 2, 1, 1, 0, "R5 R6 ilv4 top");
    idle(5, "R5 R6 ilv4 beats");
    step(1, 'h101, 1, 1, 1, 0, "R3 R5 ilv2");
    idle(3, "R3 R7 ilv2 beats");
    step(1, 'h1FF, 1, 0, 1, 0, "R4 R6 lin2 top");
    idle(3, "R4 R6 lin2 beats");
    step(1, 'h0C7, 0, 0, 1, 0, "R3 R7 bl1");
    idle(2, "R7 R11 bl1 end");
    step(1, 'h055, 0, 1, 1, 0, "R7 bl1 ilv");
    step(1, 'h0AA, 0, 0, 1, 0, "R7 R9 bl1 back to back");
    idle(1, "R11 idle");

    // R8 clock enable gaps
    step(1, 'h13D, 3, 0, 1, 0, "R8 start");
    step(0, 0, 0, 0, 1, 0, "R8 beat");
    step(0, 0, 0, 0, 0, 0, "R8 freeze");
    step(1, 'h077, 1, 1, 0, 0, "R8 start ignored while suspended");
    step(0, 0, 0, 0, 0, 0, "R8 freeze again");
    idle(7, "R8 resume");
    step(1, 'h012, 1, 0, 1, 0, "R8 last frozen");
    step(0, 0, 0, 0, 1, 0, "R8 at last");
    step(0, 0, 0, 0, 0, 0, "R7 R8 last held");
    idle(2, "R8 finish");

    // R9 restart mid burst
    step(1, 'h0F0, 3, 1, 1, 0, "R9 first");
    idle(2, "R9 run");
    step(1, 'h1C6, 2, 0, 1, 0, "R9 restart");
    idle(5, "R9 new burst");
    step(1, 'h021, 3, 0, 1, 0, "R9 a");
    idle(7, "R9 to last");
    step(1, 'h18B, 1, 1, 1, 0, "R9 restart on last");
    idle(3, "R9 tail");

    // R10 termination
    step(1, 'h0E4, 3, 0, 1, 0, "R10 start");
    idle(2, "R10 run");
    step(0, 0, 0, 0, 1, 1, "R10 terminate");
    idle(2, "R10 R11 after stop");
    step(1, 'h0E4, 3, 1, 1, 0, "R10 start b");
    step(0, 0, 0, 0, 0, 1, "R10 terminate while suspended");
    idle(1, "R10 stays idle");
    step(1, 'h033, 2, 0, 1, 0, "R10 start c");
    step(1, 'h144, 2, 1, 1, 1, "R10 start wins over terminate");
    idle(5, "R10 new burst runs");
    step(1, 'h099, 2, 0, 0, 1, "R10 suspended start plus terminate");
    idle(2, "R10 idle");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule